// File: doc/BRIEF.md
# Double-Banked Staged Key Store

This block holds the precomputed 128-bit words that feed each stage of a pipelined authenticated cipher. The AES round keys come first, followed by three hash constants. There are two independent channels, transmit and receive. Each channel keeps two banks of stage words. The datapath sees only the active bank. A write-only processor port fills the other bank one bus word at a time.

A one-cycle activate pulse on a channel exchanges its banks. The exchange does not happen everywhere at once: it moves through the stages one per clock. Early pipeline stages therefore pick up the new key while later stages are still finishing the previous packet, so a key change costs no pipeline bubble. The activate pulse is meant to come one clock before that channel's packet start.

A write aimed at a stage whose exchange is still pending lands in the bank that is about to become active. Such a write is still performed, and it marks the channel as misconfigured until reset.

Top module: `stage_key_store`

## Requirements
- R1: The write address is {stage[4:0], channel, word}. The word field is 2 bits for a 32-bit bus (address bits [7:3] stage, [2] channel, [1:0] word) and 3 bits for a 16-bit bus. Channel 0 is transmit and channel 1 is receive.
- R2: Word 0 of a stage is its most significant bus-width slice. Higher word numbers fill successively lower slices.
- R3: With a 128-bit key there are 14 stages: 11 round keys followed by 3 hash constants. With a 256-bit key there are 18 stages. Stage k is presented on bits [128k+127:128k] of that channel's key output.
- R4: A processor write goes to the inactive bank of the addressed channel and stage. The active words on the outputs do not change until an activation reaches that stage.
- R5: The two channels are fully independent. Writes, activations and misconfiguration flags of one channel never affect the other channel.
- R6: After the clock edge that samples an activate pulse, stage 0 shows the other bank. Stage k shows it k edges later, so the last stage has switched NSTG-1 edges after the first.
- R7: New words written in ascending stage order, starting the cycle after an activation, all land in the new inactive bank and do not set the misconfiguration flag.
- R8: A write that is made in the same cycle as its channel's activate pulse, or that targets a stage whose switch is still pending, is performed into the bank about to become active. It also sets that channel's misconfiguration flag, which stays set until reset.
- R9: A write whose stage number is NSTG or larger is ignored.
- R10: After reset every stage word of both banks is zero, bank 0 is active everywhere, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Processor write strobe |
| wr_addr | input | 6+log2(128/DATA_W) | Stage, channel and word address |
| wr_data | input | DATA_W | Processor write data |
| tx_act | input | 1 | Transmit bank exchange pulse |
| rx_act | input | 1 | Receive bank exchange pulse |
| tx_keys | output | NSTG*128 | Active transmit stage words |
| rx_keys | output | NSTG*128 | Active receive stage words |
| tx_misconfig | output | 1 | Sticky flag for a transmit write during a pending switch |
| rx_misconfig | output | 1 | Sticky flag for a receive write during a pending switch |

## Verification
The hardest case to reach is a write that collides with an exchange still travelling through the stages. It needs a write issued within a few cycles after an activate pulse to a stage the switch has not yet reached. The bench reaches it by pulsing activate and issuing the write on the very next cycle, to a late stage. It also runs the benign counterpart: an ascending reload started at that same moment. It then follows the ripple edge by edge, comparing the whole output vector after every clock.

// File: rtl/stage_key_store.sv
module stage_key_store #(
  parameter int DATA_W = 32,
  parameter bit KEY256 = 1'b0,
  localparam int NSTG = KEY256 ? 18 : 14,
  localparam int WPS  = 128 / DATA_W,
  localparam int WB   = $clog2(WPS),
  localparam int AW   = 6 + WB,
  localparam int SW   = $clog2(NSTG),
  localparam int KW   = NSTG * 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_act,
  input  logic              rx_act,
  output logic [KW-1:0]     tx_keys,
  output logic [KW-1:0]     rx_keys,
  output logic              tx_misconfig,
  output logic              rx_misconfig
);

  wire [4:0]    a_stg  = wr_addr[AW-1 -: 5];
  wire          a_ch   = wr_addr[WB];
  wire [WB-1:0] a_word = wr_addr[WB-1:0];
  wire [SW-1:0] a_idx  = a_stg[SW-1:0];
  wire          a_ok   = int'(a_stg) < NSTG;
  wire [6:0]    top    = 7'(127 - DATA_W * int'(a_word));
  wire [1:0]    act    = {rx_act, tx_act};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [127:0]    mem [2][NSTG];
    logic [NSTG-1:0] sel;
    logic [NSTG-1:1] pend;
    logic            bad;
    logic            late;
    logic [KW-1:0]   kv;
    wire             hit = wr_en && a_ok && (a_ch == 1'(c));

    always_comb begin
      late = act[c];
      for (int j = 1; j < NSTG; j++)
        if (j <= int'(a_stg) && pend[j]) late = 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        sel  <= '0;
        pend <= '0;
        bad  <= 1'b0;
        for (int b = 0; b < 2; b++)
          for (int s = 0; s < NSTG; s++)
            mem[b][s] <= '0;
      end else begin
        sel[0]  <= sel[0] ^ act[c];
        pend[1] <= act[c];
        for (int k = 1; k < NSTG; k++) sel[k] <= sel[k] ^ pend[k];
        for (int k = 2; k < NSTG; k++) pend[k] <= pend[k-1];
        if (hit) begin
          mem[~sel[a_idx]][a_idx][top -: DATA_W] <= wr_data;
          if (late) bad <= 1'b1;
        end
      end
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_out
      assign kv[k*128 +: 128] = mem[sel[k]][k];
    end
  end

  assign tx_keys      = g_ch[0].kv;
  assign rx_keys      = g_ch[1].kv;
  assign tx_misconfig = g_ch[0].bad;
  assign rx_misconfig = g_ch[1].bad;

endmodule

module stage_key_store_chk #(
  parameter int NSTG = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 tx_act,
  input logic                 rx_act,
  input logic [NSTG*128-1:0]  tx_keys,
  input logic [NSTG*128-1:0]  rx_keys,
  input logic                 tx_misconfig,
  input logic                 rx_misconfig
);

  logic [4:0] cnt_t, cnt_r;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_t <= 5'(NSTG - 1);
      cnt_r <= 5'(NSTG - 1);
    end else begin
      if (tx_act) cnt_t <= '0;
      else if (int'(cnt_t) < NSTG - 1) cnt_t <= cnt_t + 5'd1;
      if (rx_act) cnt_r <= '0;
      else if (int'(cnt_r) < NSTG - 1) cnt_r <= cnt_r + 5'd1;
    end
  end

  wire quiet_t = !tx_act && int'(cnt_t) >= NSTG - 1;
  wire quiet_r = !rx_act && int'(cnt_r) >= NSTG - 1;

  assert_tx_active_held_R4: assert property (@(posedge clk) disable iff (rst)
    quiet_t |=> $stable(tx_keys));
  assert_rx_active_held_R4: assert property (@(posedge clk) disable iff (rst)
    quiet_r |=> $stable(rx_keys));
  assert_tx_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    tx_misconfig |=> tx_misconfig);
  assert_rx_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    rx_misconfig |=> rx_misconfig);
  assert_tx_flag_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_misconfig) |-> $past(wr_en));
  assert_rx_flag_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_misconfig) |-> $past(wr_en));
  assert_tx_no_flag_when_settled_R7: assert property (@(posedge clk) disable iff (rst)
    quiet_t |=> $stable(tx_misconfig));
  assert_rx_no_flag_when_settled_R7: assert property (@(posedge clk) disable iff (rst)
    quiet_r |=> $stable(rx_misconfig));

endmodule

bind stage_key_store stage_key_store_chk #(.NSTG(NSTG)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .tx_act(tx_act), .rx_act(rx_act),
  .tx_keys(tx_keys), .rx_keys(rx_keys),
  .tx_misconfig(tx_misconfig), .rx_misconfig(rx_misconfig)
);

// File: tb/stage_key_store_tb_top.sv
module stage_key_store_tb_top;
  localparam int PERIOD = 10;
  localparam int NS = 14;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic tx_act = 1'b0, rx_act = 1'b0;
  logic [NS*128-1:0] tx_keys, rx_keys;
  logic tx_misconfig, rx_misconfig;

  int total = 0, bad = 0;
  bit done = 0;
  logic [127:0] cur [2][NS];
  logic [127:0] nxt [2][NS];

  always #(PERIOD/2) clk = ~clk;

  stage_key_store dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_act(tx_act), .rx_act(rx_act), .tx_keys(tx_keys), .rx_keys(rx_keys),
    .tx_misconfig(tx_misconfig), .rx_misconfig(rx_misconfig));

  function automatic logic [127:0] pat(int g, int c, int s);
    return {8'(g), 8'(c), 8'(s), 8'h5a, 32'h2222_0000 + 32'(s),
            32'h3333_0000 + 32'(g), 32'h4444_0000 + 32'(c)};
  endfunction

  function automatic logic [NS*128-1:0] outv(int c);
    return c == 0 ? tx_keys : rx_keys;
  endfunction

  function automatic logic [NS*128-1:0] model(int c);
    logic [NS*128-1:0] v;
    for (int s = 0; s < NS; s++) v[s*128 +: 128] = cur[c][s];
    return v;
  endfunction

  task automatic chk(string tag, logic [NS*128-1:0] got, logic [NS*128-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk1(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic wr(int c, int s, int w, logic [DW-1:0] d);
    wr_en = 1'b1;
    wr_addr = {5'(s), 1'(c), 2'(w)};
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(int c, int s, logic [127:0] v);
    for (int w = 0; w < 4; w++) wr(c, s, w, v[127 - 32*w -: 32]);
    if (s < NS) nxt[c][s] = v;
  endtask

  task automatic swap_model(int c);
    for (int s = 0; s < NS; s++) begin
      logic [127:0] t;
      t = cur[c][s];
      cur[c][s] = nxt[c][s];
      nxt[c][s] = t;
    end
  endtask

  task automatic pulse(int c);
    if (c == 0) tx_act = 1'b1; else rx_act = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_act = 1'b0;
    rx_act = 1'b0;
  endtask

  task automatic settle();
    repeat (NS + 1) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 tx zero", tx_keys, '0);
    chk("R10 rx zero", rx_keys, '0);
    chk1("R10 tx flag", tx_misconfig, 1'b0);
    chk1("R10 rx flag", rx_misconfig, 1'b0);
  endtask

  task automatic t_load_and_swap();
    for (int s = 0; s < NS; s++) load(0, s, pat(1, 0, s));
    chk("R4 tx active untouched by writes", tx_keys, model(0));
    pulse(0); swap_model(0); settle();
    chk("R1 R2 tx words in place after swap", tx_keys, model(0));
    chk("R3 last stage holds last word", tx_keys[(NS-1)*128 +: 128], {{(NS-1)*128{1'b0}}, pat(1, 0, NS-1)});
    chk("R5 rx untouched by tx", rx_keys, model(1));
  endtask

  task automatic t_ripple();
    logic [NS*128-1:0] e;
    for (int s = 0; s < NS; s++) load(1, s, pat(2, 1, s));
    chk("R4 rx active untouched by writes", rx_keys, model(1));
    pulse(1);
    for (int k = 0; k < NS; k++) begin
      for (int s = 0; s < NS; s++) e[s*128 +: 128] = (s <= k) ? nxt[1][s] : cur[1][s];
      chk($sformatf("R6 ripple step %0d", k), rx_keys, e);
      @(negedge clk);
    end
    swap_model(1);
    chk("R6 rx settled", rx_keys, model(1));
    chk("R5 tx held during rx ripple", tx_keys, model(0));
  endtask

  task automatic t_ascending();
    pulse(0); swap_model(0);
    for (int s = 0; s < NS; s++) load(0, s, pat(3, 0, s));
    chk1("R7 no flag on ascending reload", tx_misconfig, 1'b0);
    chk("R7 tx active is swapped bank", tx_keys, model(0));
    pulse(0); swap_model(0); settle();
    chk("R7 reload becomes active", tx_keys, model(0));
  endtask

  task automatic t_collision();
    pulse(1); swap_model(1);
    wr(1, 12, 0, 32'hdead_beef);
    cur[1][12][127:96] = 32'hdead_beef;
    chk1("R8 rx flag set by late write", rx_misconfig, 1'b1);
    chk1("R5 tx flag unaffected", tx_misconfig, 1'b0);
    settle();
    chk("R8 late write landed in new active bank", rx_keys, model(1));
    load(1, 3, pat(4, 1, 3));
    chk1("R8 rx flag sticky", rx_misconfig, 1'b1);
  endtask

  task automatic t_out_of_range();
    load(0, 20, pat(9, 0, 20));
    load(0, 31, pat(9, 0, 31));
    load(0, NS, pat(9, 0, NS));
    pulse(0); swap_model(0); settle();
    chk("R9 out-of-range stages ignored", tx_keys, model(0));
    chk1("R9 no flag from ignored writes", tx_misconfig, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < NS; s++) begin cur[c][s] = '0; nxt[c][s] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_and_swap();
    t_ripple();
    t_ascending();
    t_collision();
    t_out_of_range();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule